// File: doc/BRIEF.md
# Down-Counting Interval Timer with Single-Step Control

This block is a register-mapped interval timer. A counter counts down by one on each cycle where the tick enable is high. When a counted step takes it from 1 to 0, the block sets a sticky event flag. That flag, gated by an enable bit, drives the interrupt output. The counter then either reloads from a modulus register or runs on freely through zero to all ones. Software sets up the period and mode through three word-addressed registers: the modulus (read/write), the live count (read only) and a control word. It then only has to clear the flag on each event.

For bring-up and debug, counting can be paused in two ways. One is a halt bit. The other is a freeze that applies only while the debug input is high and the freeze-enable bit is set. While halted, software can move the counter down one step at a time. A step is refused when it would take the counter from 1 to 0 or from 0 onward. The counter can also be loaded from the modulus in two ways: with a self-clearing load bit, or, when overwrite is enabled, directly by a modulus write. A system needing two timers places two copies at different base addresses.

Top module: `itmr_top`

## Requirements
- R1: After reset the modulus, the count and every control bit are zero and the interrupt output is low.
- R2: Address 0 holds the modulus. It reads back the low CNT_W bits written, and the bits above CNT_W read as zero.
- R3: Address 2 is the control word. Bit 8 is halt, bit 7 is step, bit 6 is load, bit 5 is debug-freeze enable, bit 4 is overwrite enable, bit 3 is interrupt enable, bit 2 is the event flag and bit 1 is reload mode. Step and load always read 0, and so do bit 0 and bits 9 and up.
- R4: With reload mode set, each tick decrements the count. A tick at count 1 (or at 0) loads the modulus instead, and a tick at count 1 sets the flag. The event period is therefore modulus ticks.
- R5: With reload mode clear, a tick at 1 gives 0 and sets the flag. A tick at 0 gives all ones and does not set the flag.
- R6: In a cycle with tick enable low, the count does not change unless a register write changes it.
- R7: While halt is set, ticks have no effect. While freeze enable is set and the debug input is high, ticks have no effect. With freeze enable clear, the debug input has no effect.
- R8: A control write with step and halt both 1, made while already halted, decrements the count by one when the count is 2 or more. At count 1 or 0 the count is left unchanged.
- R9: Writing 1 to load copies the modulus into the count on the next clock. Loading, stepping or overwriting never sets the flag, including when the value is zero. Only a counted step from 1 to 0 sets it.
- R10: With overwrite enable set, a modulus write also sets the count to the written value. With it clear, the count is left unchanged.
- R11: The interrupt output is high exactly when the flag and interrupt enable are both 1. Writing 1 to the flag bit clears it, and writing 0 to it leaves it unchanged.
- R12: The read data is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Count enable, one decrement per high cycle |
| dbg_i | input | 1 | Debug-mode indication for freezing |
| addr_i | input | 2 | Word address: 0 modulus, 1 count, 2 control |
| wdata_i | input | DATA_W | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, combinational, zero when not reading |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps reload periods from one to six ticks and compares every count against an arithmetic model. A wrong reload boundary would show up as a period one tick too long or too short, or as a missed flag at modulus 1. It drives free-running mode through zero and into all ones. A design that flags on the 0-to-all-ones wrap, or that reloads there, is caught. It tries steps at counts 2, 1 and 0. A design that lets a step reach 0, set the flag or wrap would show the wrong count. It also loads a zero modulus with the interrupt enabled, which exposes a flag raised by a direct write. The bench checks freezing with the debug input both honoured and ignored, and the overwrite path both on and off.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    // control word bit positions (software visible layout)
    localparam int unsigned BIT_RLD  = 1;
    localparam int unsigned BIT_FLAG = 2;
    localparam int unsigned BIT_IEN  = 3;
    localparam int unsigned BIT_OVW  = 4;
    localparam int unsigned BIT_FRZ  = 5;
    localparam int unsigned BIT_LOAD = 6;
    localparam int unsigned BIT_STEP = 7;
    localparam int unsigned BIT_HALT = 8;

    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_MOD = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTL = 2'd2;

    typedef struct packed {
        logic halt;
        logic frz;
        logic ovw;
        logic ien;
        logic flag;
        logic rld;
    } ctl_t;
endpackage

// File: rtl/itmr_cnt_path.sv
module itmr_cnt_path #(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] mod_i,
    input  logic             rld_i,
    input  logic             run_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_floor;
    logic step_ok;

    always_comb begin
        at_floor = (cnt_i <= ONE);
        step_ok  = step_i && !at_floor;
        expire_o = run_i && (cnt_i == ONE);
        if (run_i) begin
            cnt_o = (rld_i && at_floor) ? mod_i : cnt_i - ONE;
        end else if (step_ok) begin
            cnt_o = cnt_i - ONE;
        end else begin
            cnt_o = cnt_i;
        end
    end
endmodule

// File: rtl/itmr_rdmux.sv
module itmr_rdmux
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  mod_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  ctl_t              ctl_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] ctl_word;

    always_comb begin
        ctl_word           = '0;
        ctl_word[BIT_HALT] = ctl_i.halt;
        ctl_word[BIT_FRZ]  = ctl_i.frz;
        ctl_word[BIT_OVW]  = ctl_i.ovw;
        ctl_word[BIT_IEN]  = ctl_i.ien;
        ctl_word[BIT_FLAG] = ctl_i.flag;
        ctl_word[BIT_RLD]  = ctl_i.rld;

        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                ADR_MOD: rdata_o = DATA_W'(mod_i);
                ADR_CNT: rdata_o = DATA_W'(cnt_i);
                ADR_CTL: rdata_o = ctl_word;
                default: rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_en_i,
    input  logic              dbg_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] modv;
        logic [CNT_W-1:0] cnt;
        ctl_t             ctl;
    } state_t;

    state_t st_q, st_d;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_q;
    ctl_t             ctl_q;
    logic             wr_mod;
    logic             wr_ctl;
    logic             run;
    logic             step_req;
    logic [CNT_W-1:0] cnt_nx;
    logic             expire;

    assign cnt_q = st_q.cnt;
    assign mod_q = st_q.modv;
    assign ctl_q = st_q.ctl;

    assign wr_mod   = wr_en_i && (addr_i == ADR_MOD);
    assign wr_ctl   = wr_en_i && (addr_i == ADR_CTL);
    assign run      = tick_en_i && !ctl_q.halt && !(ctl_q.frz && dbg_i);
    assign step_req = wr_ctl && ctl_q.halt && wdata_i[BIT_HALT] && wdata_i[BIT_STEP];

    itmr_cnt_path #(.CNT_W(CNT_W)) u_cnt (
        .cnt_i    (cnt_q),
        .mod_i    (mod_q),
        .rld_i    (ctl_q.rld),
        .run_i    (run),
        .step_i   (step_req),
        .cnt_o    (cnt_nx),
        .expire_o (expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nx;
        if (wr_ctl) begin
            st_d.ctl.halt = wdata_i[BIT_HALT];
            st_d.ctl.frz  = wdata_i[BIT_FRZ];
            st_d.ctl.ovw  = wdata_i[BIT_OVW];
            st_d.ctl.ien  = wdata_i[BIT_IEN];
            st_d.ctl.rld  = wdata_i[BIT_RLD];
            if (wdata_i[BIT_FLAG]) begin
                st_d.ctl.flag = 1'b0;
            end
            if (wdata_i[BIT_LOAD]) begin
                st_d.cnt = st_q.modv;
            end
        end
        if (wr_mod) begin
            st_d.modv = wdata_i[CNT_W-1:0];
            if (ctl_q.ovw) begin
                st_d.cnt = wdata_i[CNT_W-1:0];
            end
        end
        if (expire) begin
            st_d.ctl.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    itmr_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .mod_i   (mod_q),
        .cnt_i   (cnt_q),
        .ctl_i   (ctl_q),
        .rdata_o (rdata_o)
    );

    assign irq_o = ctl_q.flag && ctl_q.ien;
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [CNT_W-1:0]  cnt_q,
    input ctl_t              ctl_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R6
    a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_en_i && !wr_en_i) |=> $stable(cnt_q));

    // R7
    a_r7_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.halt && !wr_en_i) |=> $stable(cnt_q));

    // R8
    a_r8_step_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.halt && cnt_q <= ONE && wr_en_i && addr_i == ADR_CTL && !wdata_i[BIT_LOAD])
        |=> $stable(cnt_q));

    // R4
    a_r4_flag_on_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_en_i && !ctl_q.halt && !ctl_q.frz && cnt_q == ONE) |=> ctl_q.flag);

    // R9
    a_r9_flag_only_from_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctl_q.flag) |-> ($past(cnt_q) == ONE));

    // R11
    a_r11_clear_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADR_CTL && wdata_i[BIT_FLAG] && !tick_en_i) |=> !irq_o);

    // R12
    a_r12_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |-> (rdata_o == '0));
endmodule

bind itmr_top itmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .cnt_q     (cnt_q),
    .ctl_q     (ctl_q)
);

// File: tb/itmr_top_tb_top.sv
`timescale 1ns/1ps
module itmr_top_tb_top;
    import itmr_pkg::*;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              dbg = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    itmr_top #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_en_i (tick_en),
        .dbg_i     (dbg),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .rdata_o   (rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
        #1;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c;
        bit f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(ADR_MOD, v); chk("R1 modulus", v, 0);
        rd(ADR_CNT, v); chk("R1 count", v, 0);
        rd(ADR_CTL, v); chk("R1 control", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 modulus read-back and width
        wr(ADR_MOD, 32'h0000_ABCD);
        rd(ADR_MOD, v); chk("R2 modulus", v, 32'hABCD);
        wr(ADR_MOD, 32'hFFFF_FFFF);
        rd(ADR_MOD, v); chk("R2 upper zero", v, 32'h0000_FFFF);

        // R3 control layout: all ones written
        wr(ADR_CTL, 32'hFFFF_FFFF);
        rd(ADR_CTL, v); chk("R3 control layout", v, 32'h13A);
        rd(ADR_CNT, v); chk("R9 load copies modulus", v, 32'hFFFF);
        wr(ADR_CTL, 32'h0);

        // R4 reload sweep, modulus 1..6
        for (int m = 1; m <= 6; m++) begin
            wr(ADR_MOD, m);
            wr(ADR_CTL, 32'h046);
            c = m;
            for (int k = 0; k < 2 * m + 1; k++) begin
                tick(1);
                f = (c == 1);
                c = (c <= 1) ? m : c - 1;
                rd(ADR_CNT, v); chk("R4 count", v, c);
                rd(ADR_CTL, v); chk("R4 flag", {31'd0, v[BIT_FLAG]}, {31'd0, f});
                if (f) wr(ADR_CTL, 32'h006);
            end
        end

        // R5 free-running
        wr(ADR_MOD, 3);
        wr(ADR_CTL, 32'h044);
        tick(3);
        rd(ADR_CNT, v); chk("R5 reaches zero", v, 0);
        rd(ADR_CTL, v); chk("R5 flag at zero", {31'd0, v[BIT_FLAG]}, 1);
        wr(ADR_CTL, 32'h004);
        tick(1);
        rd(ADR_CNT, v); chk("R5 wrap to ones", v, 32'hFFFF);
        rd(ADR_CTL, v); chk("R5 no flag on wrap", {31'd0, v[BIT_FLAG]}, 0);
        tick(1);
        rd(ADR_CNT, v); chk("R5 continue", v, 32'hFFFE);

        // R6 no tick, no change
        repeat (5) @(negedge clk);
        rd(ADR_CNT, v); chk("R6 idle hold", v, 32'hFFFE);

        // R7 halt and debug freeze
        wr(ADR_CTL, 32'h100);
        tick(4);
        rd(ADR_CNT, v); chk("R7 halted", v, 32'hFFFE);
        wr(ADR_CTL, 32'h020);
        dbg = 1'b1;
        tick(3);
        rd(ADR_CNT, v); chk("R7 frozen in debug", v, 32'hFFFE);
        dbg = 1'b0;
        tick(2);
        rd(ADR_CNT, v); chk("R7 freeze enable, debug low", v, 32'hFFFC);
        wr(ADR_CTL, 32'h000);
        dbg = 1'b1;
        tick(1);
        rd(ADR_CNT, v); chk("R7 debug ignored", v, 32'hFFFB);
        dbg = 1'b0;

        // R8 single step
        wr(ADR_MOD, 3);
        wr(ADR_CTL, 32'h140);
        rd(ADR_CNT, v); chk("R9 load while halted", v, 3);
        wr(ADR_CTL, 32'h180);
        rd(ADR_CNT, v); chk("R8 step 3 to 2", v, 2);
        wr(ADR_CTL, 32'h180);
        rd(ADR_CNT, v); chk("R8 step 2 to 1", v, 1);
        wr(ADR_CTL, 32'h180);
        rd(ADR_CNT, v); chk("R8 step at 1 ignored", v, 1);
        rd(ADR_CTL, v); chk("R8 no flag from step", {31'd0, v[BIT_FLAG]}, 0);

        // R9 zero load raises no flag
        wr(ADR_MOD, 0);
        wr(ADR_CTL, 32'h148);
        rd(ADR_CNT, v); chk("R9 zero load", v, 0);
        rd(ADR_CTL, v); chk("R9 zero load no flag", {31'd0, v[BIT_FLAG]}, 0);
        chk("R9 zero load no irq", {31'd0, irq}, 0);
        wr(ADR_CTL, 32'h180);
        rd(ADR_CNT, v); chk("R8 step at 0 ignored", v, 0);

        // R10 overwrite
        wr(ADR_MOD, 5);
        wr(ADR_CTL, 32'h140);
        wr(ADR_MOD, 9);
        rd(ADR_CNT, v); chk("R10 no overwrite", v, 5);
        rd(ADR_MOD, v); chk("R10 modulus updated", v, 9);
        wr(ADR_CTL, 32'h110);
        wr(ADR_MOD, 7);
        rd(ADR_CNT, v); chk("R10 overwrite", v, 7);

        // R11 interrupt gating and clear
        wr(ADR_MOD, 2);
        wr(ADR_CTL, 32'h04E);
        chk("R11 irq before event", {31'd0, irq}, 0);
        tick(2);
        #1 chk("R11 irq on event", {31'd0, irq}, 1);
        wr(ADR_CTL, 32'h00A);
        #1 chk("R11 write 0 keeps flag", {31'd0, irq}, 1);
        wr(ADR_CTL, 32'h00E);
        #1 chk("R11 write 1 clears", {31'd0, irq}, 0);
        tick(2);
        wr(ADR_CTL, 32'h002);
        #1 chk("R11 masked", {31'd0, irq}, 0);
        rd(ADR_CTL, v); chk("R11 flag set while masked", {31'd0, v[BIT_FLAG]}, 1);

        // R12 idle read data
        @(negedge clk);
        addr = ADR_MOD; rd_en = 1'b0;
        #1 chk("R12 rdata idle", rdata, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule